// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block runs next to a processor's program counter and removes the branch instructions from tight inner loops. A setup strobe arms it with a loop. The loop is either a block of instructions running from a start address to an end address, or a single instruction that is repeated. The setup also carries an iteration count. While the loop is armed, the block compares the address of each instruction that completes with the end address. On a match it steers the next program counter back to the start address in the same cycle, so no cycle is lost. When the count runs out it lets the core's own next address through and raises a single-cycle completion pulse.

The count field is `CNT_W` bits wide. A count of zero requests the largest possible number of passes (2^CNT_W, which is 256 by default), never zero passes. While a single-instruction repeat is in progress the block raises an interrupt-hold output, and the interrupt controller uses it to defer service until the repeat ends. Only one loop level exists. A setup that arrives while a loop is armed is dropped and flagged.

The control is a three-state machine. IDLE goes to BLOCK on a setup with the repeat bit clear. IDLE goes to REPEAT on a setup with the repeat bit set. BLOCK and REPEAT both return to IDLE on the final end-address match. Every other case stays in the current state: a stalled cycle, a non-final match, or a rejected setup.

Top module: `loop_seq`

## Requirements
- R1: After reset the block is in IDLE. In IDLE, `loop_act`, `irq_hold`, `done` and `setup_err` are low and `pc_next` equals `pc_default`.
- R2: A `setup_vld` pulse in IDLE captures the start address, end address and count. `loop_act` goes high from the following cycle.
- R3: In a cycle where the loop is active, `adv` is high, `pc_cur` equals the end address and more than one pass remains, `pc_next` equals the start address in that same cycle. The remaining count drops by one.
- R4: On the end-address match when exactly one pass remains, `pc_next` equals `pc_default` and `done` is high for that one cycle. From the next cycle the block is IDLE.
- R5: A loaded count of 0 yields 2^CNT_W passes. A nonzero count N yields N passes.
- R6: With `setup_rpt` = 1, the start and end addresses both take `setup_start` and `setup_end` is ignored. The instruction at that address completes exactly count times.
- R7: `irq_hold` is high in exactly the cycles where a single-instruction repeat is active. It is never high during a block loop.
- R8: `setup_vld` while the loop is active raises `setup_err` in that cycle. The captured addresses and the remaining count are not changed.
- R9: A cycle with `adv` low neither redirects nor decrements, even when `pc_cur` equals the end address. `pc_next` equals `pc_default`.
- R10: In any cycle with no end-address match, `pc_next` equals `pc_default`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv | input | 1 | Instruction at `pc_cur` completes this cycle |
| pc_cur | input | ADDR_W | Address of the current instruction |
| pc_default | input | ADDR_W | Next address chosen by the core without loop control |
| setup_vld | input | 1 | Loop setup request |
| setup_rpt | input | 1 | 1 = repeat the single instruction at `setup_start` |
| setup_start | input | ADDR_W | First address of the loop body |
| setup_end | input | ADDR_W | Last address of the loop body (block mode only) |
| setup_cnt | input | CNT_W | Pass count; 0 means 2^CNT_W |
| pc_next | output | ADDR_W | Next program counter |
| loop_act | output | 1 | A loop is armed |
| irq_hold | output | 1 | Interrupt deferral during a single-instruction repeat |
| done | output | 1 | One-cycle pulse on the final pass |
| setup_err | output | 1 | Setup rejected because a loop is active |

## Verification
The hardest condition to reach from the ports is the exhaustion of a full-range count with `adv` stalls scattered across it. The bench must emulate a fetch loop that feeds `pc_next` back into `pc_cur` for hundreds of cycles, and the wrap must still land on the correct pass. Directed runs with a zero count in both modes and with a count of 2^CNT_W-1 provide that case. Constrained-random runs vary the body length, count and stall pattern, and they also inject setup requests at random points in armed loops. Some of those requests land on the very cycle that `done` fires, where a rejected setup meets the return to IDLE.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BLOCK  = 2'd1,
        ST_REPEAT = 2'd2
    } lp_state_e;

endpackage

// File: rtl/loop_bounds.sv
module loop_bounds #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_rpt,
    input  logic [ADDR_W-1:0] ld_start,
    input  logic [ADDR_W-1:0] ld_end,
    input  logic [ADDR_W-1:0] pc_cur,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic              at_end
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (load) begin
            start_q <= ld_start;
            end_q   <= ld_rpt ? ld_start : ld_end;
        end
    end

    assign at_end = (pc_cur == end_q);

endmodule

// File: rtl/loop_count.sv
module loop_count #(
    parameter int CNT_W = 8,
    localparam int RW   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] ld_cnt,
    input  logic             dec,
    output logic [RW-1:0]    rem_q,
    output logic             last
);

    localparam logic [RW-1:0] FULL = RW'(1) << CNT_W;

    logic [RW-1:0] ld_val;

    always_comb begin
        if (ld_cnt == '0) ld_val = FULL;
        else              ld_val = {1'b0, ld_cnt};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rem_q <= '0;
        else if (load) rem_q <= ld_val;
        else if (dec)  rem_q <= rem_q - RW'(1);
    end

    assign last = (rem_q == RW'(1));

endmodule

// File: rtl/loop_fsm.sv
module loop_fsm
    import loop_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      setup_vld,
    input  logic      setup_rpt,
    input  logic      hit,
    input  logic      last,
    output lp_state_e state_q,
    output logic      accept,
    output logic      reject,
    output logic      wrap,
    output logic      finish,
    output logic      active,
    output logic      rpt_active
);

    lp_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (setup_vld) state_d = setup_rpt ? ST_REPEAT : ST_BLOCK;
            end
            ST_BLOCK, ST_REPEAT: begin
                if (hit && last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        active     = (state_q != ST_IDLE);
        rpt_active = (state_q == ST_REPEAT);
        accept     = !active && setup_vld;
        reject     = active && setup_vld;
        wrap       = active && hit && !last;
        finish     = active && hit && last;
    end

endmodule

// File: rtl/loop_seq.sv
module loop_seq
    import loop_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] pc_default,
    input  logic              setup_vld,
    input  logic              setup_rpt,
    input  logic [ADDR_W-1:0] setup_start,
    input  logic [ADDR_W-1:0] setup_end,
    input  logic [CNT_W-1:0]  setup_cnt,
    output logic [ADDR_W-1:0] pc_next,
    output logic              loop_act,
    output logic              irq_hold,
    output logic              done,
    output logic              setup_err
);

    localparam int RW = CNT_W + 1;

    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] end_q;
    logic [RW-1:0]     rem_q;
    logic              at_end;
    logic              last;
    logic              hit;
    logic              accept;
    logic              reject;
    logic              wrap;
    logic              finish;
    logic              active;
    logic              rpt_active;
    lp_state_e         state_q;

    assign hit = adv && at_end;

    loop_bounds #(.ADDR_W(ADDR_W)) u_bounds (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .ld_rpt   (setup_rpt),
        .ld_start (setup_start),
        .ld_end   (setup_end),
        .pc_cur   (pc_cur),
        .start_q  (start_q),
        .end_q    (end_q),
        .at_end   (at_end)
    );

    loop_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .ld_cnt (setup_cnt),
        .dec    (wrap),
        .rem_q  (rem_q),
        .last   (last)
    );

    loop_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_vld  (setup_vld),
        .setup_rpt  (setup_rpt),
        .hit        (hit),
        .last       (last),
        .state_q    (state_q),
        .accept     (accept),
        .reject     (reject),
        .wrap       (wrap),
        .finish     (finish),
        .active     (active),
        .rpt_active (rpt_active)
    );

    always_comb begin
        pc_next   = wrap ? start_q : pc_default;
        loop_act  = active;
        irq_hold  = rpt_active;
        done      = finish;
        setup_err = reject;
    end

endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    localparam int RW    = CNT_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv,
    input logic [ADDR_W-1:0] pc_cur,
    input logic [ADDR_W-1:0] pc_default,
    input logic              setup_vld,
    input logic              setup_rpt,
    input logic [CNT_W-1:0]  setup_cnt,
    input logic [ADDR_W-1:0] pc_next,
    input logic              loop_act,
    input logic              irq_hold,
    input logic              done,
    input logic              setup_err,
    input logic [ADDR_W-1:0] start_q,
    input logic [ADDR_W-1:0] end_q,
    input logic [RW-1:0]     rem_q
);

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_act |-> (pc_next == pc_default) && !done && !irq_hold && !setup_err); // R1

    AST_SETUP_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_vld && !loop_act) |=> loop_act); // R2

    AST_WRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_act && adv && pc_cur == end_q && rem_q > RW'(1)) |-> (pc_next == start_q)); // R3

    AST_WRAP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_act && adv && pc_cur == end_q && rem_q > RW'(1)) |=> (rem_q == $past(rem_q) - RW'(1))); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !loop_act)); // R4

    AST_ZERO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_vld && !loop_act && setup_cnt == '0) |=> (rem_q == (RW'(1) << CNT_W))); // R5

    AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hold |-> loop_act); // R7

    AST_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_hold) |-> $past(setup_vld && setup_rpt && !loop_act)); // R7

    AST_ERR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        setup_err |-> loop_act); // R8

    AST_ERR_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        setup_err |=> ($stable(start_q) && $stable(end_q))); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_act && !adv) |=> $stable(rem_q)); // R9

    AST_NO_MATCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_cur != end_q) |-> (pc_next == pc_default)); // R10

endmodule

bind loop_seq loop_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv         (adv),
    .pc_cur      (pc_cur),
    .pc_default  (pc_default),
    .setup_vld   (setup_vld),
    .setup_rpt   (setup_rpt),
    .setup_cnt   (setup_cnt),
    .pc_next     (pc_next),
    .loop_act    (loop_act),
    .irq_hold    (irq_hold),
    .done        (done),
    .setup_err   (setup_err),
    .start_q     (start_q),
    .end_q       (end_q),
    .rem_q       (rem_q)
);

// File: tb/loop_seq_tb.sv
module loop_seq_tb;

    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv = 1'b0;
    logic [AW-1:0] pc_cur = '0;
    logic [AW-1:0] pc_default = '0;
    logic          setup_vld = 1'b0;
    logic          setup_rpt = 1'b0;
    logic [AW-1:0] setup_start = '0;
    logic [AW-1:0] setup_end = '0;
    logic [CW-1:0] setup_cnt = '0;
    logic [AW-1:0] pc_next;
    logic          loop_act;
    logic          irq_hold;
    logic          done;
    logic          setup_err;

    loop_seq #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .pc_cur(pc_cur),
        .pc_default(pc_default), .setup_vld(setup_vld), .setup_rpt(setup_rpt),
        .setup_start(setup_start), .setup_end(setup_end), .setup_cnt(setup_cnt),
        .pc_next(pc_next), .loop_act(loop_act), .irq_hold(irq_hold),
        .done(done), .setup_err(setup_err)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int seed_dummy;

    bit          m_act = 0;
    bit          m_rpt = 0;
    logic [AW-1:0] m_start = '0;
    logic [AW-1:0] m_end = '0;
    int          m_rem = 0;
    logic [AW-1:0] pc = 16'h0100;
    int          hits = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish (act=%0d exp=finish)", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int load_val(input logic [CW-1:0] c);
        return (c == 0) ? (1 << CW) : int'(c);
    endfunction

    // One cycle: inputs already set after negedge; compare, update model, advance.
    task automatic step();
        bit hit;
        bit e_done;
        logic [AW-1:0] e_pc;
        string pc_tag;
        #2;
        hit    = m_act && adv && (pc_cur == m_end);
        e_done = hit && (m_rem == 1);
        e_pc   = (hit && m_rem > 1) ? m_start : pc_default;
        pc_tag = !adv ? "R9" : (hit ? ((m_rem > 1) ? "R3" : "R4") : "R10");
        check(pc_tag, 32'(pc_next), 32'(e_pc));
        check("R2 loop_act", 32'(loop_act), 32'(m_act));
        check("R4 done", 32'(done), 32'(e_done));
        check("R7 irq_hold", 32'(irq_hold), 32'(m_act && m_rpt));
        check("R8 setup_err", 32'(setup_err), 32'(setup_vld && m_act));
        if (hit) hits++;
        if (!m_act && setup_vld) begin
            m_act   = 1;
            m_rpt   = setup_rpt;
            m_start = setup_start;
            m_end   = setup_rpt ? setup_start : setup_end;
            m_rem   = load_val(setup_cnt);
        end else if (hit) begin
            if (m_rem > 1) m_rem--;
            else m_act = 0;
        end
        if (adv) pc = e_pc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_plain(input bit a);
        adv        = a;
        pc_cur     = pc;
        pc_default = pc + 16'd1;
        setup_vld  = 1'b0;
    endtask

    // Arm a loop starting right after the current instruction and run it out.
    task automatic run_loop(input bit rpt, input int len, input logic [CW-1:0] cnt,
                            input int stall_pct, input int inj_pct);
        int exp_passes;
        drive_plain(1'b1);
        setup_vld   = 1'b1;
        setup_rpt   = rpt;
        setup_start = pc + 16'd1;
        setup_end   = pc + 16'd1 + 16'(len);
        setup_cnt   = cnt;
        exp_passes  = load_val(cnt);
        step();
        hits = 0;
        while (m_act) begin
            drive_plain(($urandom_range(99) >= stall_pct) ? 1'b1 : 1'b0);
            if ($urandom_range(99) < inj_pct) begin
                setup_vld   = 1'b1;
                setup_rpt   = 1'($urandom);
                setup_start = 16'($urandom);
                setup_end   = 16'($urandom);
                setup_cnt   = 8'($urandom);
            end
            step();
        end
        if (rpt) check("R6 repeat passes", 32'(hits), 32'(exp_passes));
        else     check("R5 block passes", 32'(hits), 32'(exp_passes));
    endtask

    initial begin
        seed_dummy = $urandom(32'h1F0C);
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset loop_act", 32'(loop_act), 32'd0);
        check("R1 reset irq_hold", 32'(irq_hold), 32'd0);
        check("R1 reset done", 32'(done), 32'd0);
        pc_default = 16'h1234;
        #1;
        check("R1 reset pc_next", 32'(pc_next), 32'h1234);
        @(negedge clk);
        rst_n = 1'b1;
        drive_plain(1'b1);
        step();

        // Directed corners
        run_loop(1'b1, 0, 8'd0, 10, 0);   // R5 R6: repeat 256 times with stalls
        run_loop(1'b0, 1, 8'd0, 5, 0);    // R5: block, 256 passes
        run_loop(1'b0, 3, 8'd1, 0, 0);    // R4: single pass falls through
        run_loop(1'b1, 0, 8'd1, 0, 0);    // R6: single repeat
        run_loop(1'b0, 0, 8'd255, 20, 0); // R5: one-instruction block, 255 passes
        run_loop(1'b1, 5, 8'd4, 0, 100);  // R6 R8: setup_end ignored, setup every cycle

        // Constrained random
        for (int i = 0; i < 300; i++) begin
            int idle_n = $urandom_range(3);
            for (int k = 0; k < idle_n; k++) begin
                drive_plain(1'($urandom));
                step();
            end
            run_loop(1'($urandom), $urandom_range(4), 8'($urandom_range(1, 6)),
                     $urandom_range(30), $urandom_range(15));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule